// File: doc/BRIEF.md
# Frame Buffer Fetch Engine

This block reads one display frame from memory for a raster display controller and feeds it to the pixel path as 32-bit words through an internal FIFO. Software programs a start address and an inclusive last-word address. It also programs a burst size, a load mode and the pixel depth, then sets the raster enable. The engine walks the buffer in bursts and restarts at the start address once the last word of a pass has been requested. Returned words are queued in order for a pixel consumer that pops one word at a time.

The front of every buffer holds a colour palette. Its size is 32 bytes at 4 bits per pixel and 512 bytes at 8 bits per pixel. A load mode can limit each pass to that palette region. The end of each pass is recorded in a sticky status bit. Popping an empty queue while the raster is on is also recorded. Each status bit can raise the interrupt output when its enable is set, and software clears a bit by writing a one to it.

Top module: `fb_fetch_engine`

## Requirements
- R1: After reset, every register reads 0, no memory request is made, `irq` is 0 and `pix_valid` is 0.
- R2: The burst code in DMA-control bits 6:4 selects 1, 2, 4, 8 or 16 words for codes 0 to 4, and 16 words for codes 5 to 7. Every request other than the last of a pass has exactly that length.
- R3: Requests cover consecutive word addresses from the start register upward. The last request of a pass is shortened so that it ends exactly on the ceiling address, which is itself fetched. No address above the ceiling is requested.
- R4: After the last word of a pass, the next request starts again at the start address. Words reach `pix_data` in address order across the wrap.
- R5: Raster-control bits 21:20 hold the load mode. Value 01 limits each pass to the palette region, which ends 32 bytes after the start when raster bit 1 is 0 and 512 bytes after it when that bit is 1. The ceiling applies if it comes first. Every other value fetches up to the ceiling.
- R6: A request is made only when the FIFO has at least the full burst size of free entries. This applies even to a shortened request.
- R7: Status bit 8 is set when the final word of a pass arrives. `irq` is raised while that bit is set and DMA-control bit 2 is 1.
- R8: Status bit 5 is set when `pix_pop` is high with the FIFO empty while the raster (raster-control bit 0) is enabled. It is not set while the raster is disabled. `irq` is raised while bit 5 is set and raster-control bit 6 is 1.
- R9: Writing the status register clears each status bit that is 1 in the written value. Bits written as 0 are left unchanged.
- R10: While the raster is disabled, no request is made and the word pointer returns to the start address. Data beats that arrive in that time are dropped.
- R11: DMA-control bit 0 (dual buffer) always reads 0. The two low bits of the start and ceiling registers always read 0.
- R12: Register indices on `reg_addr` are 0 = DMA control, 1 = start, 2 = ceiling, 3 = raster control, 4 = status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the first word of the burst |
| mem_len | output | 5 | Burst length in words |
| mem_ready | input | 1 | Request accepted on this edge when `mem_req` is high |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| pix_pop | input | 1 | Pixel consumer takes the head word |
| pix_data | output | 32 | Head word of the FIFO |
| pix_valid | output | 1 | FIFO holds at least one word |
| irq | output | 1 | Interrupt, level |

## Verification
The hardest state to reach from the ports is a FIFO that runs dry while the raster is still enabled. Normally the memory model refills it faster than the consumer drains it. The bench reaches it by holding the memory side idle and popping continuously after enable. In the same way, it stalls the consumer to pin the FIFO near full, which shows that requests stop once fewer than a full burst of entries remain. Randomised passes mix burst codes, frame lengths that are not multiples of the burst, both load modes and random handshake gaps. A scoreboard predicts every request address and length, and every popped word across the frame wrap.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int LEN_W = 5;

    typedef enum logic [2:0] {
        RI_DMA    = 3'd0,
        RI_BASE   = 3'd1,
        RI_CEIL   = 3'd2,
        RI_RASTER = 3'd3,
        RI_STAT   = 3'd4
    } reg_idx_e;

    localparam logic [1:0] LM_PALETTE = 2'b01;

    typedef struct packed {
        logic          en;
        logic          bpp8;
        logic          pal_only;
        logic [2:0]    bcode;
        logic [AW-1:0] base;
        logic [AW-1:0] ceil;
    } fetch_cfg_t;

    function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [AW-1:0] palette_bytes(input logic bpp8);
        return bpp8 ? 32'd512 : 32'd32;
    endfunction
endpackage

// File: rtl/fbf_regs.sv
module fbf_regs
    import fbf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          eof_evt,
    input  logic          ufl_evt,
    output logic [DW-1:0] rdata,
    output fetch_cfg_t    cfg,
    output logic          st_eof,
    output logic          st_ufl,
    output logic          irq
);
    logic          eof_ie, ufl_ie, r_en, r_bpp8;
    logic [2:0]    bcode;
    logic [1:0]    lmode;
    logic [AW-1:0] base_q, ceil_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_ie <= 1'b0; ufl_ie <= 1'b0; r_en <= 1'b0; r_bpp8 <= 1'b0;
            bcode  <= '0;   lmode  <= '0;   base_q <= '0; ceil_q <= '0;
            st_eof <= 1'b0; st_ufl <= 1'b0;
        end else begin
            if (we) begin
                case (addr)
                    RI_DMA: begin
                        eof_ie <= wdata[2];
                        bcode  <= wdata[6:4];
                    end
                    RI_BASE: base_q <= {wdata[AW-1:2], 2'b00};
                    RI_CEIL: ceil_q <= {wdata[AW-1:2], 2'b00};
                    RI_RASTER: begin
                        r_en   <= wdata[0];
                        r_bpp8 <= wdata[1];
                        ufl_ie <= wdata[6];
                        lmode  <= wdata[21:20];
                    end
                    default: ;
                endcase
            end
            // event setting wins over a clear in the same cycle
            if (eof_evt)
                st_eof <= 1'b1;
            else if (we && addr == RI_STAT && wdata[8])
                st_eof <= 1'b0;
            if (ufl_evt)
                st_ufl <= 1'b1;
            else if (we && addr == RI_STAT && wdata[5])
                st_ufl <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            RI_DMA:    rdata = {25'd0, bcode, 1'b0, eof_ie, 2'b00};
            RI_BASE:   rdata = base_q;
            RI_CEIL:   rdata = ceil_q;
            RI_RASTER: rdata = {10'd0, lmode, 13'd0, ufl_ie, 4'd0, r_bpp8, r_en};
            RI_STAT:   rdata = {23'd0, st_eof, 2'd0, st_ufl, 5'd0};
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        cfg.en       = r_en;
        cfg.bpp8     = r_bpp8;
        cfg.pal_only = (lmode == LM_PALETTE);
        cfg.bcode    = bcode;
        cfg.base     = base_q;
        cfg.ceil     = ceil_q;
    end

    assign irq = (st_eof & eof_ie) | (st_ufl & ufl_ie);
endmodule

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int FREE_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              pop,
    output logic [WIDTH-1:0]  rdata,
    output logic              empty,
    output logic [FREE_W-1:0] free
);
    logic [WIDTH-1:0]  store [DEPTH];
    logic [PTR_W-1:0]  wr_p, rd_p;
    logic [FREE_W-1:0] cnt;
    logic              do_pop;

    assign empty  = (cnt == '0);
    assign do_pop = pop && !empty;
    assign free   = FREE_W'(DEPTH) - cnt;
    assign rdata  = store[rd_p];

    always_ff @(posedge clk) begin
        if (push)
            store[wr_p] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p <= '0; rd_p <= '0; cnt <= '0;
        end else begin
            if (push)   wr_p <= wr_p + 1'b1;
            if (do_pop) rd_p <= rd_p + 1'b1;
            cnt <= cnt + FREE_W'(push) - FREE_W'(do_pop);
        end
    end
endmodule

// File: rtl/fbf_seq.sv
module fbf_seq
    import fbf_pkg::*;
#(
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  fetch_cfg_t        cfg,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic              push,
    output logic              eof_evt
);
    logic [AW-1:0]    ptr, pal_end, end_addr, rem, bw_ext;
    logic [LEN_W-1:0] inflight, bw;
    logic             last_q, fire, final_req, beat;

    always_comb begin
        bw       = burst_words(cfg.bcode);
        bw_ext   = AW'(bw);
        pal_end  = cfg.base + palette_bytes(cfg.bpp8) - 32'd4;
        end_addr = (cfg.pal_only && pal_end < cfg.ceil) ? pal_end : cfg.ceil;
        rem      = ((end_addr - ptr) >> 2) + 32'd1;
        mem_len  = (rem < bw_ext) ? LEN_W'(rem) : bw;
        final_req = (AW'(mem_len) == rem);
        mem_addr = ptr;
        mem_req  = cfg.en && (inflight == '0) && (AW'(fifo_free) >= bw_ext);
        fire     = mem_req && mem_ready;
        beat     = mem_rvalid && (inflight != '0);
        push     = beat && cfg.en;
        eof_evt  = push && (inflight == 5'd1) && last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0; inflight <= '0; last_q <= 1'b0;
        end else begin
            if (fire) begin
                inflight <= mem_len;
                last_q   <= final_req;
                ptr      <= final_req ? cfg.base : ptr + (AW'(mem_len) << 2);
            end else if (beat) begin
                inflight <= inflight - 1'b1;
                if (inflight == 5'd1)
                    last_q <= 1'b0;
            end
            if (!cfg.en) begin
                ptr    <= cfg.base;
                last_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fb_fetch_engine.sv
module fb_fetch_engine
    import fbf_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             pix_pop,
    output logic [DW-1:0]    pix_data,
    output logic             pix_valid,
    output logic             irq
);
    fetch_cfg_t        cfg;
    logic              eof_evt, ufl_evt, push, fifo_empty, st_eof, st_ufl;
    logic [FREE_W-1:0] fifo_free;
    logic [AW-1:0]     cfg_ceil;
    logic              cfg_en;

    assign cfg_ceil  = cfg.ceil;
    assign cfg_en    = cfg.en;
    assign pix_valid = !fifo_empty;
    assign ufl_evt   = pix_pop && fifo_empty && cfg.en;

    fbf_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .eof_evt(eof_evt), .ufl_evt(ufl_evt), .rdata(reg_rdata), .cfg(cfg),
        .st_eof(st_eof), .st_ufl(st_ufl), .irq(irq)
    );

    fbf_seq #(.FREE_W(FREE_W)) u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .fifo_free(fifo_free),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .push(push), .eof_evt(eof_evt)
    );

    fbf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DW)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(mem_rdata), .pop(pix_pop),
        .rdata(pix_data), .empty(fifo_empty), .free(fifo_free)
    );
endmodule

// File: rtl/fb_fetch_engine_chk.sv
module fb_fetch_engine_chk #(
    parameter int FREE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic [4:0]        mem_len,
    input logic              mem_rvalid,
    input logic [31:0]       cfg_ceil,
    input logic              cfg_en,
    input logic [FREE_W-1:0] fifo_free,
    input logic              st_eof,
    input logic              st_ufl,
    input logic              pix_pop,
    input logic              pix_valid,
    input logic              irq,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_rdata
);
    p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != 5'd0 && mem_len <= 5'd16));

    p_under_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr + ((32'(mem_len) - 32'd1) << 2) <= cfg_ceil));

    p_room_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(fifo_free) >= 32'(mem_len)));

    p_eof_on_beat_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_eof) |-> $past(mem_rvalid));

    p_ufl_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(st_ufl) |-> $past(pix_pop && !pix_valid && cfg_en));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_eof || st_ufl));

    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> !mem_req);

    p_single_buffer_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd0) |-> (reg_rdata[0] == 1'b0));
endmodule

bind fb_fetch_engine fb_fetch_engine_chk #(.FREE_W(FREE_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_rvalid(mem_rvalid), .cfg_ceil(cfg_ceil),
    .cfg_en(cfg_en), .fifo_free(fifo_free), .st_eof(st_eof), .st_ufl(st_ufl),
    .pix_pop(pix_pop), .pix_valid(pix_valid), .irq(irq),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_fb_fetch_engine.sv
module tb_fb_fetch_engine;
    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [4:0]  mem_len;
    logic        pix_pop = 1'b0, pix_valid, irq;
    logic [31:0] pix_data;

    int n_chk = 0, n_bad = 0;
    bit mem_hold = 1'b0, req_chk = 1'b0, cons_chk = 1'b0;
    int cons_mode = 0;              // 0 stall, 1 random, 2 always
    logic [31:0] beatq[$];
    logic [31:0] e_base, e_end, e_req, e_rd, first_req;
    int e_bw, req_words, req_cnt, pop_cnt, first_len;

    always #2 clk = ~clk;

    fb_fetch_engine dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_pop(pix_pop),
        .pix_data(pix_data), .pix_valid(pix_valid), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bwords(input int code);
        return (code >= 4) ? 16 : (1 << code);
    endfunction

    function automatic logic [31:0] next_addr(input logic [31:0] a);
        return (a == e_end) ? e_base : a + 32'd4;
    endfunction

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // memory model: beats first, then the request accepted at the coming edge
    always @(negedge clk) begin
        logic rdy;
        int   rem, el;
        if (beatq.size() != 0 && !mem_hold && ($urandom % 3) != 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = ~beatq.pop_front();
        end else begin
            mem_rvalid = 1'b0;
        end
        rdy = !mem_hold && (($urandom % 4) != 0);
        if (!rst && mem_req && rdy) begin
            if (req_cnt == 0) begin first_req = mem_addr; first_len = int'(mem_len); end
            req_cnt++;
            req_words += int'(mem_len);
            if (req_chk) begin
                rem = int'((e_end - e_req) >> 2) + 1;
                el  = (rem < e_bw) ? rem : e_bw;
                chk(mem_addr == e_req, "R3 request address", mem_addr, e_req);
                chk(int'(mem_len) == el, "R2 request length", 32'(mem_len), 32'(el));
                for (int i = 0; i < el; i++) e_req = next_addr(e_req);
            end
            for (int i = 0; i < int'(mem_len); i++) beatq.push_back(mem_addr + 32'(4 * i));
        end
        mem_ready = rdy;
    end

    // pixel consumer with in-order scoreboard
    always @(negedge clk) begin
        case (cons_mode)
            0:       pix_pop = 1'b0;
            1:       pix_pop = ($urandom % 2) != 0;
            default: pix_pop = 1'b1;
        endcase
        if (pix_pop && pix_valid) begin
            pop_cnt++;
            if (cons_chk) begin
                chk(pix_data == ~e_rd, "R4 pixel word order", pix_data, ~e_rd);
                e_rd = next_addr(e_rd);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic quiesce();
        wr(3'd3, 32'd0);
        req_chk = 1'b0; cons_chk = 1'b0; cons_mode = 2;
        for (int i = 0; i < 3000 && (beatq.size() != 0 || pix_valid); i++) @(negedge clk);
        repeat (4) @(negedge clk);
        cons_mode = 0;
        wr(3'd4, 32'hFFFF_FFFF);
    endtask

    // start a pass: raster value is (lm<<20)|(ufl_ie<<6)|(bpp8<<1)|en
    task automatic start(input logic [31:0] base, input int nwords, input int bcode,
                         input logic [1:0] lm, input bit bpp8, input bit eofie, input bit uflie);
        logic [31:0] ceil, pend;
        ceil = base + 32'(4 * (nwords - 1));
        pend = base + (bpp8 ? 32'd512 : 32'd32) - 32'd4;
        wr(3'd1, base);
        wr(3'd2, ceil);
        wr(3'd0, (32'(bcode) << 4) | (32'(eofie) << 2));
        e_base = base;
        e_end  = (lm == 2'b01 && pend < ceil) ? pend : ceil;
        e_req  = base; e_rd = base; e_bw = bwords(bcode);
        req_words = 0; req_cnt = 0; pop_cnt = 0;
        req_chk = 1'b1; cons_chk = 1'b1;
        wr(3'd3, (32'(lm) << 20) | (32'(uflie) << 6) | (32'(bpp8) << 1) | 32'd1);
    endtask

    initial begin
        #(4 * 190000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        logic [31:0] v;
        int nw, fw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state; R12 register indices
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk(v == 32'd0, "R1 R12 register reset value", v, 32'd0);
        end
        chk(!mem_req && !irq && !pix_valid, "R1 idle outputs", {mem_req, irq, pix_valid}, 32'd0);

        // R11 read-back masking
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v);
        chk(v == 32'h74, "R11 dual-buffer bit reads 0", v, 32'h74);
        wr(3'd1, 32'h0000_1003); rd(3'd1, v);
        chk(v == 32'h1000, "R11 start low bits", v, 32'h1000);
        wr(3'd2, 32'h0000_2FFF); rd(3'd2, v);
        chk(v == 32'h2FFC, "R11 ceiling low bits", v, 32'h2FFC);

        // R6 stalled consumer: two 16-word bursts fill a 32-entry FIFO
        quiesce();
        start(32'h1000, 100, 4, 2'b00, 1'b0, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        chk(req_words == 32, "R6 words requested with stalled consumer", 32'(req_words), 32'd32);

        // R10 disable stops requests, restart from start address
        wr(3'd3, 32'd0);
        req_cnt = 0;
        repeat (60) @(negedge clk);
        chk(req_cnt == 0, "R10 no request while disabled", 32'(req_cnt), 32'd0);
        quiesce();
        start(32'h1000, 100, 4, 2'b00, 1'b0, 1'b0, 1'b0);
        cons_mode = 1;
        repeat (200) @(negedge clk);
        chk(first_req == 32'h1000, "R10 restart at start address", first_req, 32'h1000);

        // R2 R3 R4 R7 short frame with a shortened last burst, wraps
        quiesce();
        start(32'h4000, 22, 2, 2'b00, 1'b0, 1'b1, 1'b0);
        cons_mode = 2;
        repeat (400) @(negedge clk);
        chk(pop_cnt > 22, "R4 fetch continues past one pass", 32'(pop_cnt), 32'd23);
        rd(3'd4, v);
        chk(v[8] == 1'b1, "R7 end-of-frame status", v, 32'h100);
        chk(irq == 1'b1, "R7 irq with enable", 32'(irq), 32'd1);

        // R9 write-one-to-clear
        wr(3'd3, 32'd0);
        repeat (40) @(negedge clk);
        wr(3'd4, 32'h0000_0020); rd(3'd4, v);
        chk(v[8] == 1'b1, "R9 bit written 0 stays set", v, 32'h100);
        wr(3'd4, 32'h0000_0100); rd(3'd4, v);
        chk(v[8] == 1'b0, "R9 bit written 1 clears", v, 32'd0);

        // R5 palette only, 4 bpp: 8 words then wrap
        quiesce();
        start(32'h8000, 200, 4, 2'b01, 1'b0, 1'b0, 1'b0);
        cons_mode = 2;
        repeat (300) @(negedge clk);
        chk(first_len == 8, "R5 palette-only 4bpp burst", 32'(first_len), 32'd8);
        rd(3'd4, v);
        chk(v[8] == 1'b1, "R5 palette-only raises end of frame", v, 32'h100);
        // R5 palette only, 8 bpp: 128 words
        quiesce();
        start(32'h8000, 300, 3, 2'b01, 1'b1, 1'b0, 1'b0);
        cons_mode = 2;
        repeat (900) @(negedge clk);
        chk(pop_cnt > 128, "R5 palette-only 8bpp wraps", 32'(pop_cnt), 32'd129);
        // R5 other load-mode value fetches to ceiling
        quiesce();
        start(32'h8000, 40, 4, 2'b10, 1'b0, 1'b0, 1'b0);
        cons_mode = 2;
        repeat (300) @(negedge clk);
        chk(pop_cnt > 40, "R5 mode 10 reaches ceiling", 32'(pop_cnt), 32'd41);

        // R8 underflow with memory held off
        quiesce();
        mem_hold = 1'b1;
        start(32'h9000, 16, 0, 2'b00, 1'b0, 1'b0, 1'b1);
        cons_mode = 2;
        repeat (5) @(negedge clk);
        cons_mode = 0;
        rd(3'd4, v);
        chk(v[5] == 1'b1, "R8 underflow status", v, 32'h20);
        chk(irq == 1'b1, "R8 underflow irq", 32'(irq), 32'd1);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'hFFFF_FFFF);
        cons_mode = 2;
        repeat (5) @(negedge clk);
        cons_mode = 0;
        rd(3'd4, v);
        chk(v[5] == 1'b0, "R8 no underflow while disabled", v, 32'd0);
        mem_hold = 1'b0;

        // random passes
        for (int k = 0; k < 12; k++) begin
            logic [1:0] lm;
            bit b8;
            int bc;
            quiesce();
            nw = 1 + int'($urandom % 70);
            bc = int'($urandom % 8);
            lm = 2'($urandom % 3);
            b8 = 1'($urandom % 2);
            start(32'h1_0000 + 32'(($urandom % 256) * 4), nw, bc, lm, b8, 1'b0, 1'b0);
            fw = int'((e_end - e_base) >> 2) + 1;
            cons_mode = 1;
            for (int i = 0; i < 6000 && pop_cnt <= fw; i++) @(negedge clk);
            rd(3'd4, v);
            chk(v[8] == 1'b1, "R7 random pass end of frame", v, 32'h100);
        end
        quiesce();
        finish_up();
    end
endmodule